// File: doc/BRIEF.md
# Permutation Endgame Sequencer

This block takes over a code-breaking game at the point where the digits in the hidden four-slot code are known but their order is not. At `start_i` it latches five symbol values: A, B, C and D, which name the known digits, and E, a digit known to be absent from the code. With them it takes the repetition shape of the code (one digit twice plus two singles, or four distinct digits) and the positional match count the previous full-arrangement guess received. From these it picks one of four fixed decision trees.

It then offers one four-slot guess at a time. Each slot is a copy of one latched symbol. The guess is held until a positional match count (reds) is returned for it. Probe guesses padded with E separate the candidate orders, and a list of fall-back orders is walked until one scores four. On a guess that must be correct by the tree's logic, the block raises `expect_solved_o`. A win, or any score the tree cannot explain, ends the walk with a one-cycle pulse and returns the block to idle.

Top module: `ecs_endgame_seq`

## Requirements
- R1: The guess is `guess_o` = {slot0, slot1, slot2, slot3}, with slot0 (leftmost) in bits [11:9] and slot3 in bits [2:0]. Each slot equals one of the five symbol values latched at the accepted start, and later changes of the symbol inputs do not alter it.
- R2: A start in idle with shape 0 (AABC) and 2 prior reds, or shape 1 (ABCD) and 0, 1 or 2 prior reds, makes the tree's first guess valid one cycle later. Any other combination gives a one-cycle `fatal_o` pulse and the block stays idle.
- R3: In the AABC tree the first guess is AEEE. After 0 reds it guesses BAAC and then CABA. After 1 red it guesses ABAC, ACBA and AACB.
- R4: In the ABCD/0 tree the first guess is BACD, which leads on 0 reds to CDAB, on 1 red to AACD and on 2 reds to BADC. CDAB leads on 0 reds to DCBA and otherwise to DCAB, then CDBA. AACD leads on 0 reds to BCCD and on 1 red to CACD. BCCD leads on 1 or 2 reds to BDAC or BCDA. CACD leads on 1 or 2 reds to DABC or CADB.
- R5: In the ABCD/1 tree the first guess is ABEE, which leads on 0 reds to EECE and on 1 red to AEEE. EECE leads on 0 reds to CABD then BCAD, and on 1 red to DACB then BDCA. AEEE leads on 0 reds to DBAC then CBDA, and on 1 red to ADBC then ACDB.
- R6: In the ABCD/2 tree the first guess is AEEE. On 0 reds it continues with BACD, CBAD, DBCA, and on 1 red with ABDC, ACBD, ADCB.
- R7: A score of 4 reds on any valid guess gives a one-cycle `win_o` pulse in the next cycle, and the block returns to idle.
- R8: `expect_solved_o` is high exactly while the last guess of a leaf list is shown. A score other than 4 on that guess gives a `fatal_o` pulse in the next cycle and returns the block to idle.
- R9: A score that is not 4 and has no branch at the current node gives a `fatal_o` pulse in the next cycle and returns the block to idle.
- R10: `start_i` has no effect while a guess is valid, and `score_valid_i` has no effect in idle.
- R11: After reset the block is idle: `guess_valid_o`, `expect_solved_o`, `win_o` and `fatal_o` are low.
- R12: For every arrangement of the latched symbols that is consistent with the shape and the prior red count, the block wins within four guesses without a fatal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an endgame (accepted in idle only) |
| shape_i | input | 1 | 0: one digit twice plus two singles; 1: four distinct digits |
| red6_i | input | RED_W | Reds scored by the previous full-arrangement guess |
| sym_a_i | input | SYM_W | Symbol A (the doubled digit for shape 0) |
| sym_b_i | input | SYM_W | Symbol B |
| sym_c_i | input | SYM_W | Symbol C |
| sym_d_i | input | SYM_W | Symbol D (unused for shape 0) |
| sym_e_i | input | SYM_W | Filler digit absent from the code |
| score_valid_i | input | 1 | Score for the current guess is present |
| score_red_i | input | RED_W | Reds for the current guess |
| guess_valid_o | output | 1 | A guess is being offered |
| guess_o | output | 4*SYM_W | Current guess, slot0 in the top bits |
| expect_solved_o | output | 1 | Current guess must score 4 |
| win_o | output | 1 | One-cycle pulse: code solved |
| fatal_o | output | 1 | One-cycle pulse: scores inconsistent or case unsupported |

## Verification
The properties assume that a score arrives only while a guess is shown, that it never exceeds four, that E differs from every digit in the code, and that A to D are distinct. Only under those conditions does a four-red result mean the walk is over. The exhaustive games score each guess against a real arrangement of the latched symbols, so every score is one the tree can meet. The fault checks are directed on purpose. They feed impossible scores (three reds on a full arrangement, a miss on a forced guess) and unsupported start cases, so that the fatal paths are taken while the assumptions on score range and timing still hold.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int SLOTS   = 4;
    localparam int NUM_SYM = 5;

    typedef enum logic [2:0] {
        SEL_A, SEL_B, SEL_C, SEL_D, SEL_E
    } sym_sel_e;

    // index SLOTS-1 is the leftmost slot
    typedef sym_sel_e [SLOTS-1:0] pattern_t;

    typedef enum logic [5:0] {
        N_IDLE,
        N_P_AEEE, N_P_BAAC, N_P_CABA, N_P_ABAC, N_P_ACBA, N_P_AACB,
        N_Z_BACD, N_Z_CDAB, N_Z_DCBA, N_Z_DCAB, N_Z_CDBA, N_Z_AACD,
        N_Z_BCCD, N_Z_BDAC, N_Z_BCDA, N_Z_CACD, N_Z_DABC, N_Z_CADB,
        N_Z_BADC,
        N_O_ABEE, N_O_EECE, N_O_AEEE, N_O_CABD, N_O_BCAD, N_O_DACB,
        N_O_BDCA, N_O_DBAC, N_O_CBDA, N_O_ADBC, N_O_ACDB,
        N_T_AEEE, N_T_BACD, N_T_CBAD, N_T_DBCA, N_T_ABDC, N_T_ACBD,
        N_T_ADCB
    } node_e;

    typedef struct packed {
        node_e nxt;
        logic  win;
        logic  fault;
    } step_t;

    function automatic pattern_t pat(input sym_sel_e s0, input sym_sel_e s1,
                                     input sym_sel_e s2, input sym_sel_e s3);
        pattern_t p;
        p[3] = s0;
        p[2] = s1;
        p[1] = s2;
        p[0] = s3;
        return p;
    endfunction

    function automatic pattern_t node_pattern(input node_e n);
        pattern_t p;
        case (n)
            N_P_AEEE: p = pat(SEL_A, SEL_E, SEL_E, SEL_E);
            N_P_BAAC: p = pat(SEL_B, SEL_A, SEL_A, SEL_C);
            N_P_CABA: p = pat(SEL_C, SEL_A, SEL_B, SEL_A);
            N_P_ABAC: p = pat(SEL_A, SEL_B, SEL_A, SEL_C);
            N_P_ACBA: p = pat(SEL_A, SEL_C, SEL_B, SEL_A);
            N_P_AACB: p = pat(SEL_A, SEL_A, SEL_C, SEL_B);
            N_Z_BACD: p = pat(SEL_B, SEL_A, SEL_C, SEL_D);
            N_Z_CDAB: p = pat(SEL_C, SEL_D, SEL_A, SEL_B);
            N_Z_DCBA: p = pat(SEL_D, SEL_C, SEL_B, SEL_A);
            N_Z_DCAB: p = pat(SEL_D, SEL_C, SEL_A, SEL_B);
            N_Z_CDBA: p = pat(SEL_C, SEL_D, SEL_B, SEL_A);
            N_Z_AACD: p = pat(SEL_A, SEL_A, SEL_C, SEL_D);
            N_Z_BCCD: p = pat(SEL_B, SEL_C, SEL_C, SEL_D);
            N_Z_BDAC: p = pat(SEL_B, SEL_D, SEL_A, SEL_C);
            N_Z_BCDA: p = pat(SEL_B, SEL_C, SEL_D, SEL_A);
            N_Z_CACD: p = pat(SEL_C, SEL_A, SEL_C, SEL_D);
            N_Z_DABC: p = pat(SEL_D, SEL_A, SEL_B, SEL_C);
            N_Z_CADB: p = pat(SEL_C, SEL_A, SEL_D, SEL_B);
            N_Z_BADC: p = pat(SEL_B, SEL_A, SEL_D, SEL_C);
            N_O_ABEE: p = pat(SEL_A, SEL_B, SEL_E, SEL_E);
            N_O_EECE: p = pat(SEL_E, SEL_E, SEL_C, SEL_E);
            N_O_AEEE: p = pat(SEL_A, SEL_E, SEL_E, SEL_E);
            N_O_CABD: p = pat(SEL_C, SEL_A, SEL_B, SEL_D);
            N_O_BCAD: p = pat(SEL_B, SEL_C, SEL_A, SEL_D);
            N_O_DACB: p = pat(SEL_D, SEL_A, SEL_C, SEL_B);
            N_O_BDCA: p = pat(SEL_B, SEL_D, SEL_C, SEL_A);
            N_O_DBAC: p = pat(SEL_D, SEL_B, SEL_A, SEL_C);
            N_O_CBDA: p = pat(SEL_C, SEL_B, SEL_D, SEL_A);
            N_O_ADBC: p = pat(SEL_A, SEL_D, SEL_B, SEL_C);
            N_O_ACDB: p = pat(SEL_A, SEL_C, SEL_D, SEL_B);
            N_T_AEEE: p = pat(SEL_A, SEL_E, SEL_E, SEL_E);
            N_T_BACD: p = pat(SEL_B, SEL_A, SEL_C, SEL_D);
            N_T_CBAD: p = pat(SEL_C, SEL_B, SEL_A, SEL_D);
            N_T_DBCA: p = pat(SEL_D, SEL_B, SEL_C, SEL_A);
            N_T_ABDC: p = pat(SEL_A, SEL_B, SEL_D, SEL_C);
            N_T_ACBD: p = pat(SEL_A, SEL_C, SEL_B, SEL_D);
            N_T_ADCB: p = pat(SEL_A, SEL_D, SEL_C, SEL_B);
            default:  p = pat(SEL_E, SEL_E, SEL_E, SEL_E);
        endcase
        return p;
    endfunction

    // final entry of a leaf list: a miss here cannot be explained
    function automatic logic node_is_last(input node_e n);
        case (n)
            N_P_CABA, N_P_AACB,
            N_Z_DCBA, N_Z_CDBA, N_Z_BDAC, N_Z_BCDA, N_Z_DABC, N_Z_CADB,
            N_Z_BADC,
            N_O_BCAD, N_O_BDCA, N_O_CBDA, N_O_ACDB,
            N_T_DBCA, N_T_ADCB: return 1'b1;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ecs_entry_select.sv
module ecs_entry_select
    import ecs_pkg::*;
#(
    parameter int RED_W = 3
) (
    input  logic             shape,
    input  logic [RED_W-1:0] red6,
    output node_e            entry,
    output logic             supported
);
    always_comb begin
        entry     = N_IDLE;
        supported = 1'b1;
        if (!shape) begin
            if (red6 == RED_W'(2)) entry = N_P_AEEE;
            else                   supported = 1'b0;
        end else begin
            if (red6 == RED_W'(0))      entry = N_Z_BACD;
            else if (red6 == RED_W'(1)) entry = N_O_ABEE;
            else if (red6 == RED_W'(2)) entry = N_T_AEEE;
            else                        supported = 1'b0;
        end
    end
endmodule

// File: rtl/ecs_tree_step.sv
module ecs_tree_step
    import ecs_pkg::*;
#(
    parameter int RED_W = 3
) (
    input  node_e            node,
    input  logic [RED_W-1:0] red,
    output step_t            step
);
    logic r0, r1, r2, r4;
    logic uncovered;
    node_e nxt;

    assign r0 = (red == RED_W'(0));
    assign r1 = (red == RED_W'(1));
    assign r2 = (red == RED_W'(2));
    assign r4 = (red == RED_W'(4));

    always_comb begin
        nxt       = N_IDLE;
        uncovered = 1'b0;
        case (node)
            N_P_AEEE: if (r0) nxt = N_P_BAAC; else if (r1) nxt = N_P_ABAC; else uncovered = 1'b1;
            N_P_BAAC: nxt = N_P_CABA;
            N_P_ABAC: nxt = N_P_ACBA;
            N_P_ACBA: nxt = N_P_AACB;
            N_Z_BACD: begin
                if (r0)      nxt = N_Z_CDAB;
                else if (r1) nxt = N_Z_AACD;
                else if (r2) nxt = N_Z_BADC;
                else         uncovered = 1'b1;
            end
            N_Z_CDAB: nxt = r0 ? N_Z_DCBA : N_Z_DCAB;
            N_Z_DCAB: nxt = N_Z_CDBA;
            N_Z_AACD: if (r0) nxt = N_Z_BCCD; else if (r1) nxt = N_Z_CACD; else uncovered = 1'b1;
            N_Z_BCCD: if (r1) nxt = N_Z_BDAC; else if (r2) nxt = N_Z_BCDA; else uncovered = 1'b1;
            N_Z_CACD: if (r1) nxt = N_Z_DABC; else if (r2) nxt = N_Z_CADB; else uncovered = 1'b1;
            N_O_ABEE: if (r0) nxt = N_O_EECE; else if (r1) nxt = N_O_AEEE; else uncovered = 1'b1;
            N_O_EECE: if (r0) nxt = N_O_CABD; else if (r1) nxt = N_O_DACB; else uncovered = 1'b1;
            N_O_AEEE: if (r0) nxt = N_O_DBAC; else if (r1) nxt = N_O_ADBC; else uncovered = 1'b1;
            N_O_CABD: nxt = N_O_BCAD;
            N_O_DACB: nxt = N_O_BDCA;
            N_O_DBAC: nxt = N_O_CBDA;
            N_O_ADBC: nxt = N_O_ACDB;
            N_T_AEEE: if (r0) nxt = N_T_BACD; else if (r1) nxt = N_T_ABDC; else uncovered = 1'b1;
            N_T_BACD: nxt = N_T_CBAD;
            N_T_CBAD: nxt = N_T_DBCA;
            N_T_ABDC: nxt = N_T_ACBD;
            N_T_ACBD: nxt = N_T_ADCB;
            default:  nxt = N_IDLE;
        endcase
    end

    always_comb begin
        step.nxt   = nxt;
        step.win   = r4;
        step.fault = !r4 && (uncovered || node_is_last(node));
    end
endmodule

// File: rtl/ecs_guess_mux.sv
module ecs_guess_mux
    import ecs_pkg::*;
#(
    parameter int SYM_W = 3
) (
    input  pattern_t                 sel,
    input  logic [NUM_SYM*SYM_W-1:0] sym_flat,
    output logic [SLOTS*SYM_W-1:0]   guess
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_comb begin
            case (sel[s])
                SEL_A:   guess[s*SYM_W +: SYM_W] = sym_flat[0*SYM_W +: SYM_W];
                SEL_B:   guess[s*SYM_W +: SYM_W] = sym_flat[1*SYM_W +: SYM_W];
                SEL_C:   guess[s*SYM_W +: SYM_W] = sym_flat[2*SYM_W +: SYM_W];
                SEL_D:   guess[s*SYM_W +: SYM_W] = sym_flat[3*SYM_W +: SYM_W];
                default: guess[s*SYM_W +: SYM_W] = sym_flat[4*SYM_W +: SYM_W];
            endcase
        end
    end
endmodule

// File: rtl/ecs_endgame_seq.sv
module ecs_endgame_seq
    import ecs_pkg::*;
#(
    parameter int SYM_W = 3,
    parameter int RED_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   shape_i,
    input  logic [RED_W-1:0]       red6_i,
    input  logic [SYM_W-1:0]       sym_a_i,
    input  logic [SYM_W-1:0]       sym_b_i,
    input  logic [SYM_W-1:0]       sym_c_i,
    input  logic [SYM_W-1:0]       sym_d_i,
    input  logic [SYM_W-1:0]       sym_e_i,
    input  logic                   score_valid_i,
    input  logic [RED_W-1:0]       score_red_i,
    output logic                   guess_valid_o,
    output logic [SLOTS*SYM_W-1:0] guess_o,
    output logic                   expect_solved_o,
    output logic                   win_o,
    output logic                   fatal_o
);
    localparam int SYM_BITS = NUM_SYM * SYM_W;

    node_e                node_q;
    logic [SYM_BITS-1:0]  sym_q;
    logic                 win_q, fatal_q;
    node_e                entry_node;
    logic                 entry_ok;
    step_t                step;
    logic                 busy;

    assign busy = (node_q != N_IDLE);

    ecs_entry_select #(.RED_W(RED_W)) entry_i (
        .shape     (shape_i),
        .red6      (red6_i),
        .entry     (entry_node),
        .supported (entry_ok)
    );

    ecs_tree_step #(.RED_W(RED_W)) step_i (
        .node (node_q),
        .red  (score_red_i),
        .step (step)
    );

    ecs_guess_mux #(.SYM_W(SYM_W)) mux_i (
        .sel      (node_pattern(node_q)),
        .sym_flat (sym_q),
        .guess    (guess_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q  <= N_IDLE;
            sym_q   <= '0;
            win_q   <= 1'b0;
            fatal_q <= 1'b0;
        end else begin
            win_q   <= 1'b0;
            fatal_q <= 1'b0;
            if (!busy) begin
                if (start_i) begin
                    sym_q <= {sym_e_i, sym_d_i, sym_c_i, sym_b_i, sym_a_i};
                    if (entry_ok) node_q  <= entry_node;
                    else          fatal_q <= 1'b1;
                end
            end else if (score_valid_i) begin
                if (step.win) begin
                    win_q  <= 1'b1;
                    node_q <= N_IDLE;
                end else if (step.fault) begin
                    fatal_q <= 1'b1;
                    node_q  <= N_IDLE;
                end else begin
                    node_q <= step.nxt;
                end
            end
        end
    end

    assign guess_valid_o   = busy;
    assign expect_solved_o = busy && node_is_last(node_q);
    assign win_o           = win_q;
    assign fatal_o         = fatal_q;
endmodule

// File: rtl/ecs_endgame_chk.sv
module ecs_endgame_chk #(
    parameter int SYM_W = 3,
    parameter int RED_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               score_valid_i,
    input logic [RED_W-1:0]   score_red_i,
    input logic               guess_valid_o,
    input logic [4*SYM_W-1:0] guess_o,
    input logic               expect_solved_o,
    input logic               win_o,
    input logic               fatal_o
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(win_o && fatal_o)); // R7
    AST_WIN_AFTER_FOUR: assert property (@(posedge clk) disable iff (rst)
        guess_valid_o && score_valid_i && score_red_i == RED_W'(4)
        |=> win_o && !guess_valid_o); // R7
    AST_MISS_ON_FORCED: assert property (@(posedge clk) disable iff (rst)
        guess_valid_o && score_valid_i && expect_solved_o && score_red_i != RED_W'(4)
        |=> fatal_o && !guess_valid_o); // R8
    AST_FORCED_NEEDS_GUESS: assert property (@(posedge clk) disable iff (rst)
        expect_solved_o |-> guess_valid_o); // R8
    AST_GUESS_HELD: assert property (@(posedge clk) disable iff (rst)
        guess_valid_o && !score_valid_i |=> guess_valid_o && $stable(guess_o)); // R10
    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !guess_valid_o && !start_i |=> !guess_valid_o && !win_o); // R10
endmodule

bind ecs_endgame_seq ecs_endgame_chk #(.SYM_W(SYM_W), .RED_W(RED_W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .score_valid_i   (score_valid_i),
    .score_red_i     (score_red_i),
    .guess_valid_o   (guess_valid_o),
    .guess_o         (guess_o),
    .expect_solved_o (expect_solved_o),
    .win_o           (win_o),
    .fatal_o         (fatal_o)
);

// File: tb/ecs_endgame_seq_tb.sv
`timescale 1ns/1ps
module ecs_endgame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        shape_i = 1'b0;
    logic [2:0]  red6_i = '0;
    logic [2:0]  sym_a_i = '0, sym_b_i = '0, sym_c_i = '0, sym_d_i = '0, sym_e_i = '0;
    logic        score_valid_i = 1'b0;
    logic [2:0]  score_red_i = '0;
    logic        guess_valid_o;
    logic [11:0] guess_o;
    logic        expect_solved_o, win_o, fatal_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ecs_endgame_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .shape_i(shape_i), .red6_i(red6_i),
        .sym_a_i(sym_a_i), .sym_b_i(sym_b_i), .sym_c_i(sym_c_i), .sym_d_i(sym_d_i),
        .sym_e_i(sym_e_i), .score_valid_i(score_valid_i), .score_red_i(score_red_i),
        .guess_valid_o(guess_valid_o), .guess_o(guess_o),
        .expect_solved_o(expect_solved_o), .win_o(win_o), .fatal_o(fatal_o)
    );

    // row: [7] shape, [6:4] prior reds, [3:0] number of consistent codes
    localparam logic [7:0] CASES [4] = '{8'h25, 8'h89, 8'h98, 8'hA6};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic sh, input logic [2:0] r6, input logic [2:0] a,
                            input logic [2:0] b, input logic [2:0] c, input logic [2:0] d,
                            input logic [2:0] e);
        start_i = 1'b1; shape_i = sh; red6_i = r6;
        sym_a_i = a; sym_b_i = b; sym_c_i = c; sym_d_i = d; sym_e_i = e;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic give_score(input logic [2:0] r);
        score_valid_i = 1'b1; score_red_i = r;
        @(negedge clk);
        score_valid_i = 1'b0;
    endtask

    // secret slots hold symbol indices 0..3 (A..D); symbol value = index + 1, E = 0
    task automatic play(input logic sh, input logic [2:0] r6, input int s0, input int s1,
                        input int s2, input int s3, output int ng, output bit won,
                        output bit bad);
        int sec[4];
        sec = '{s0, s1, s2, s3};
        do_start(sh, r6, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0);
        ng = 0; won = 0; bad = 0;
        for (int g = 0; g < 6; g++) begin
            int reds;
            bit ex;
            if (won || bad) break;
            if (!guess_valid_o) begin bad = 1; break; end
            reds = 0;
            for (int k = 0; k < 4; k++)
                if (guess_o[(3-k)*3 +: 3] == 3'(sec[k] + 1)) reds++;
            ex = expect_solved_o;
            ng++;
            give_score(3'(reds));
            if (win_o) won = 1;
            else if (fatal_o) bad = 1;
            if (ex && reds != 4) bad = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!guess_valid_o && !expect_solved_o && !win_o && !fatal_o, "R11 reset idle",
              {guess_valid_o, expect_solved_o, win_o, fatal_o}, 0);

        // exhaustive games per case
        for (int row = 0; row < 4; row++) begin
            logic sh;
            logic [2:0] r6;
            int played;
            string req;
            sh = CASES[row][7]; r6 = CASES[row][6:4];
            req = (row == 0) ? "R3" : (row == 1) ? "R4" : (row == 2) ? "R5" : "R6";
            played = 0;
            for (int i0 = 0; i0 < 4; i0++)
            for (int i1 = 0; i1 < 4; i1++)
            for (int i2 = 0; i2 < 4; i2++)
            for (int i3 = 0; i3 < 4; i3++) begin
                int cnt[4];
                int six[4];
                int sec[4];
                int m;
                bit fits;
                int ng;
                bit won, bad;
                sec = '{i0, i1, i2, i3};
                cnt = '{0, 0, 0, 0};
                for (int k = 0; k < 4; k++) cnt[sec[k]]++;
                if (!sh) begin
                    fits = (cnt[0] == 2 && cnt[1] == 1 && cnt[2] == 1);
                    six = '{0, 0, 1, 2};
                end else begin
                    fits = (cnt[0] == 1 && cnt[1] == 1 && cnt[2] == 1 && cnt[3] == 1);
                    six = '{0, 1, 2, 3};
                end
                m = 0;
                for (int k = 0; k < 4; k++) if (sec[k] == six[k]) m++;
                if (fits && m == int'(r6)) begin
                    play(sh, r6, i0, i1, i2, i3, ng, won, bad);
                    // R12 plus the tree of this row
                    check(won && !bad && ng <= 4, {req, "/R12 win within four"},
                          {i0[3:0], i1[3:0], i2[3:0], i3[3:0], 4'(ng)}, 4);
                    check(!guess_valid_o, {req, " idle after win"}, guess_valid_o, 0);
                    played++;
                end
            end
            check(played == int'(CASES[row][3:0]), {req, " consistent code count"},
                  played, CASES[row][3:0]);
        end

        // R1: symbols latched at start, BACD with A=5,B=4,C=3,D=2,E=1
        do_start(1'b1, 3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1);
        check(guess_o == 12'h95A && guess_valid_o, "R1 first guess slots", guess_o, 12'h95A);
        check(!expect_solved_o, "R8 probe not forced", expect_solved_o, 0);
        sym_a_i = 0; sym_b_i = 0; sym_c_i = 0; sym_d_i = 0; sym_e_i = 0;
        @(negedge clk);
        check(guess_o == 12'h95A, "R1 inputs changed after start", guess_o, 12'h95A);
        // R10 start while busy ignored
        do_start(1'b0, 3'd2, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1);
        check(guess_o == 12'h95A && guess_valid_o && !fatal_o, "R10 start while busy",
              guess_o, 12'h95A);
        // R9 three reds on BACD has no branch
        give_score(3'd3);
        check(fatal_o && !guess_valid_o, "R9 uncovered score", {fatal_o, guess_valid_o}, 2);

        // R2 unsupported case
        do_start(1'b0, 3'd1, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0);
        check(fatal_o && !guess_valid_o, "R2 unsupported case", {fatal_o, guess_valid_o}, 2);
        @(negedge clk);
        check(!fatal_o, "R2 fatal is one cycle", fatal_o, 0);

        // R4 path BACD -1-> AACD with A..D=1..4
        do_start(1'b1, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0);
        give_score(3'd1);
        check(guess_o == 12'h25C && guess_valid_o, "R4 AACD after one red", guess_o, 12'h25C);
        give_score(3'd4);
        check(win_o && !guess_valid_o, "R7 win on four", {win_o, guess_valid_o}, 2);
        @(negedge clk);
        check(!win_o, "R7 win is one cycle", win_o, 0);

        // R8 forced guess missed: ABCD/2, AEEE 0 -> BACD -> CBAD -> DBCA
        do_start(1'b1, 3'd2, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0);
        check(guess_o == 12'h200, "R6 first probe AEEE", guess_o, 12'h200);
        give_score(3'd0);
        give_score(3'd0);
        give_score(3'd0);
        check(guess_o == 12'h899 && expect_solved_o, "R8 DBCA forced",
              {expect_solved_o, guess_o}, {1'b1, 12'h899});
        give_score(3'd1);
        check(fatal_o && !guess_valid_o, "R8 miss on forced guess", {fatal_o, guess_valid_o}, 2);

        // R10 score in idle ignored
        give_score(3'd4);
        check(!win_o && !guess_valid_o, "R10 score while idle", {win_o, guess_valid_o}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule